// File: doc/BRIEF.md
# Multiplexed Video Bus Transmitter

This block puts one pixel and its sync controls onto a narrow 7-bit bus that runs at four times the pixel rate. Each active pixel takes four bus cycles. The first cycle is a control phase that carries the four active-low sync lines. The next three cycles carry the red, green and blue channel codes, 7 bits each. An active-low frame-sync strobe goes low in every control phase and high in every colour phase, so a receiver can find where each pixel starts.

During blanking the block sends no colour data. It repeats control phases on every bus cycle with the strobe held low, so the sync lines can move at bus-clock resolution rather than pixel resolution. A one-cycle request output tells the upstream pixel source that a pixel has been taken and the next one should be presented.

Top module: `vidbus_tx`

## Requirements
- R1: While reset is asserted, the bus is all zero, the strobe is high and the request is low. The first bus cycle after reset is released is a control phase.
- R2: An active pixel occupies four consecutive bus cycles in this order: control, red, green, blue. The next pixel's control phase follows immediately.
- R3: The strobe is low in every control phase and high in every colour phase.
- R4: In a control phase, the bus carries composite sync on bit 0, horizontal sync on bit 1, clamp on bit 2 and vertical sync on bit 3, all taken as given (active low). Bits 6..4 are zero.
- R5: When blank is high at the edge that starts a control phase, the next bus cycle is another control phase, and the sync inputs are sampled again at that cycle.
- R6: Pixel, sync and blank inputs are sampled only at the edge that starts a control phase. Changes to them during the three colour phases have no effect on the bus.
- R7: A control phase taken with blank low is always followed by the red, green and blue phases, including the first control phase after a blanking run.
- R8: The request output is high for exactly the one cycle in which the control phase of an active pixel is on the bus. It is low in blanking control phases and in colour phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, four times the pixel rate |
| rstN | input | 1 | Active-low synchronous reset |
| pixRed | input | 7 | Red channel code |
| pixGreen | input | 7 | Green channel code |
| pixBlue | input | 7 | Blue channel code |
| csyncN | input | 1 | Active-low composite sync |
| hsyncN | input | 1 | Active-low horizontal sync |
| clampN | input | 1 | Active-low clamp |
| vsyncN | input | 1 | Active-low vertical sync |
| blank | input | 1 | High while the line is blanked |
| busData | output | 7 | Multiplexed control or colour word |
| frameSyncN | output | 1 | Active-low strobe marking control phases |
| pixReq | output | 1 | One-cycle request for the next pixel |

## Verification
During every colour phase the bench drives inverted pixel, sync and blank values. A design that samples outside the control edge would show that garbage on the bus or drop out of the four-phase run.

The bench sweeps all sixteen sync patterns in both blanked and active control phases, which catches swapped bit positions. It also runs blanking stretches of one to six cycles followed by active pixels. A design that miscounts the phase at the end of blanking would skip or repeat a colour phase, or would send a colour word with the strobe low.

The request line is compared on every cycle. An extra pulse during blanking, or a pulse that lasts too long, is therefore reported.

// File: rtl/vidbus_pkg.sv
package vidbus_pkg;
  localparam int NUM_PHASES = 4;
  localparam int PHASE_W    = $clog2(NUM_PHASES);
  localparam int CTL_BITS   = 4;

  typedef struct packed {
    logic               load;       // capture inputs and emit a control phase
    logic [PHASE_W-1:0] colourSel;  // phase shown after this edge (1..3 = R,G,B)
  } vbStrobe_t;
endpackage

// File: rtl/vidbus_ctrl.sv
module vidbus_ctrl
  import vidbus_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               blank,
  output vbStrobe_t          strobe,
  output logic [PHASE_W-1:0] phase,
  output logic               pixReq
);
  localparam logic [PHASE_W-1:0] LAST = PHASE_W'(NUM_PHASES - 1);

  logic               blankHeld;
  logic               loadNow;
  logic [PHASE_W-1:0] phaseNext;

  always_comb begin
    loadNow   = (phase == LAST) || ((phase == '0) && blankHeld);
    phaseNext = loadNow ? '0 : phase + 1'b1;
    strobe.load      = loadNow;
    strobe.colourSel = phaseNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= LAST;
      blankHeld <= 1'b0;
      pixReq    <= 1'b0;
    end else begin
      phase  <= phaseNext;
      pixReq <= loadNow && !blank;
      if (loadNow) blankHeld <= blank;
    end
  end

  // R2: colour phases advance one step per cycle
  a_r2_colour_advance: assert property (@(posedge clk) disable iff (!rstN)
    (phase != '0 && phase != LAST) |=> (phase == PHASE_W'($past(phase) + 1)));

  // R5: a blanked control phase is followed by another control phase
  a_r5_blank_repeats: assert property (@(posedge clk) disable iff (!rstN)
    (phase == '0 && blankHeld) |=> (phase == '0));

  // R7: an active control phase is followed by the red phase
  a_r7_active_to_red: assert property (@(posedge clk) disable iff (!rstN)
    (phase == '0 && !blankHeld) |=> (phase == PHASE_W'(1)));

  // R8: the request never lasts more than one cycle
  a_r8_req_single: assert property (@(posedge clk) disable iff (!rstN)
    pixReq |=> !pixReq);
endmodule

// File: rtl/vidbus_dp.sv
module vidbus_dp
  import vidbus_pkg::*;
#(
  parameter int CHAN_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  vbStrobe_t         strobe,
  input  logic [CHAN_W-1:0] pixRed,
  input  logic [CHAN_W-1:0] pixGreen,
  input  logic [CHAN_W-1:0] pixBlue,
  input  logic [CTL_BITS-1:0] syncN,
  output logic [CHAN_W-1:0] busData,
  output logic              frameSyncN
);
  localparam int NUM_CHAN = NUM_PHASES - 1;

  logic [CHAN_W-1:0] pixIn [NUM_CHAN];
  logic [CHAN_W-1:0] held  [NUM_CHAN];
  logic [CHAN_W-1:0] colourWord;

  assign pixIn[0] = pixRed;
  assign pixIn[1] = pixGreen;
  assign pixIn[2] = pixBlue;

  for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rstN)            held[ch] <= '0;
      else if (strobe.load) held[ch] <= pixIn[ch];
    end
  end

  always_comb begin
    case (strobe.colourSel)
      PHASE_W'(1): colourWord = held[0];
      PHASE_W'(2): colourWord = held[1];
      default:     colourWord = held[2];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busData    <= '0;
      frameSyncN <= 1'b1;
    end else if (strobe.load) begin
      busData    <= CHAN_W'(syncN);
      frameSyncN <= 1'b0;
    end else begin
      busData    <= colourWord;
      frameSyncN <= 1'b1;
    end
  end

  // R4: upper bits are zero whenever the strobe marks a control phase
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    !frameSyncN |-> (busData[CHAN_W-1:CTL_BITS] == '0));

  // R6: held pixel stays put when no control phase starts
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(held[0]) && $stable(held[1]) && $stable(held[2])));
endmodule

// File: rtl/vidbus_tx.sv
module vidbus_tx
  import vidbus_pkg::*;
#(
  parameter int CHAN_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CHAN_W-1:0] pixRed,
  input  logic [CHAN_W-1:0] pixGreen,
  input  logic [CHAN_W-1:0] pixBlue,
  input  logic              csyncN,
  input  logic              hsyncN,
  input  logic              clampN,
  input  logic              vsyncN,
  input  logic              blank,
  output logic [CHAN_W-1:0] busData,
  output logic              frameSyncN,
  output logic              pixReq
);
  vbStrobe_t          strobe;
  logic [PHASE_W-1:0] phase;

  vidbus_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .blank  (blank),
    .strobe (strobe),
    .phase  (phase),
    .pixReq (pixReq)
  );

  vidbus_dp #(.CHAN_W(CHAN_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .pixRed     (pixRed),
    .pixGreen   (pixGreen),
    .pixBlue    (pixBlue),
    .syncN      ({vsyncN, clampN, hsyncN, csyncN}),
    .busData    (busData),
    .frameSyncN (frameSyncN)
  );

  // R3: strobe low exactly when the controller is in the control phase
  a_r3_strobe_phase: assert property (@(posedge clk) disable iff (!rstN)
    (!frameSyncN) == (phase == '0));
endmodule

// File: tb/vidbus_tx_bench.sv
module vidbus_tx_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [6:0] pixRed = '0, pixGreen = '0, pixBlue = '0;
  logic csyncN = 1'b1, hsyncN = 1'b1, clampN = 1'b1, vsyncN = 1'b1;
  logic blank = 1'b0;
  logic [6:0] busData;
  logic frameSyncN, pixReq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench-side model state
  int mPhase = 3;
  logic mBlank = 1'b0;
  logic [6:0] mHeld [3];
  logic [6:0] expBus;
  logic expFs, expReq;
  string busTag;

  always #4 clk = ~clk;

  vidbus_tx u_vidbus_tx (
    .clk(clk), .rstN(rstN), .pixRed(pixRed), .pixGreen(pixGreen),
    .pixBlue(pixBlue), .csyncN(csyncN), .hsyncN(hsyncN), .clampN(clampN),
    .vsyncN(vsyncN), .blank(blank), .busData(busData),
    .frameSyncN(frameSyncN), .pixReq(pixReq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one bus cycle: inputs driven now (at negedge), result checked at next negedge
  task automatic cyc(input logic wantBlank, input logic [3:0] syn,
                     input logic [6:0] pr, input logic [6:0] pg, input logic [6:0] pb);
    logic nl;
    nl = (mPhase == 3) || (mPhase == 0 && mBlank);
    if (nl) begin
      {vsyncN, clampN, hsyncN, csyncN} = syn;
      pixRed = pr; pixGreen = pg; pixBlue = pb; blank = wantBlank;
    end else begin
      // garbage during colour phases must be ignored (R6)
      {vsyncN, clampN, hsyncN, csyncN} = ~syn;
      pixRed = ~pr; pixGreen = ~pg; pixBlue = ~pb; blank = ~wantBlank;
    end
    @(posedge clk);
    if (nl) begin
      if (wantBlank) busTag = "R5";
      else if (mPhase == 0 && mBlank) busTag = "R7";
      else busTag = "R4";
      expBus = {3'b000, syn};
      expFs = 1'b0;
      expReq = !wantBlank;
      mHeld[0] = pr; mHeld[1] = pg; mHeld[2] = pb;
      mBlank = wantBlank;
      mPhase = 0;
    end else begin
      mPhase++;
      expBus = mHeld[mPhase-1];
      expFs = 1'b1;
      expReq = 1'b0;
      busTag = "R2/R6";
    end
    @(negedge clk);
    chk(busTag, {25'd0, busData}, {25'd0, expBus});
    chk("R3", {31'd0, frameSyncN}, {31'd0, expFs});
    chk("R8", {31'd0, pixReq}, {31'd0, expReq});
  endtask

  task automatic pixel(input int i);
    logic [6:0] r, g, b;
    r = 7'((i * 5 + 1) % 128);
    g = 7'((i * 37 + 9) % 128);
    b = 7'((i * 91 + 64) % 128);
    for (int k = 0; k < 4; k++) cyc(1'b0, 4'(i % 16), r, g, b);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {25'd0, busData}, 32'd0);
    chk("R1", {31'd0, frameSyncN}, 32'd1);
    chk("R1", {31'd0, pixReq}, 32'd0);
    rstN = 1'b1;
    // first cycle after reset: control phase
    cyc(1'b0, 4'hA, 7'h11, 7'h22, 7'h33);
    chk("R1", {31'd0, frameSyncN}, 32'd0);
    for (int k = 0; k < 3; k++) cyc(1'b0, 4'hA, 7'h11, 7'h22, 7'h33);
    // active sweep over all sync patterns and varied pixels
    for (int i = 0; i < 48; i++) pixel(i);
    // blanking runs of several lengths, then active pixels
    for (int len = 1; len <= 6; len++) begin
      for (int s = 0; s < len; s++) cyc(1'b1, 4'((len * 3 + s) % 16), 7'h7F, 7'h00, 7'h55);
      pixel(len * 7);
      pixel(len * 7 + 1);
    end
    // full sync sweep during blanking
    for (int s = 0; s < 16; s++) cyc(1'b1, 4'(s), 7'h2A, 7'h15, 7'h40);
    pixel(100);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule